// File: doc/BRIEF.md
# Descriptor Bus Sequencer

This block performs the bus-master transfers that fetch and update one DMA ring descriptor for a network controller. A request names the operation (fetch or update), the descriptor base address, the descriptor layout, burst permissions for reads and writes, and whether the buffer ends a chain. The block then drives a simplified multiplexed address/data master bus. That bus has an address phase, a turnaround on reads, data phases qualified by an active-low initiator-ready strobe, and active-low byte enables. The block hands back the descriptor fields after a fetch. On an update it writes status first and ownership last.

Requests use a valid/ready handshake. `req_ready` is high only while the sequencer is idle, so the caller holds `req_valid` and the request fields until a cycle where both are high. The layout, burst flags, base address and write words are captured in that cycle. The completion pulse `done` carries the fetched fields for exactly one cycle and has no back-pressure: the caller must take them in that cycle. The bus target is assumed always ready. Arbitration and target termination are handled outside this block.

Layout codes on `req_layout`: 0 = 16-bit layout, 1 = 32-bit layout, 2 = 32-bit burst-ordered layout, 3 = treated as the 32-bit layout.

Top module: `desc_bus_seq`

## Requirements
- R1: A request is accepted on a cycle with `req_valid` and `req_ready` both high. `req_ready` is high only while the bus is released (`bus_frame_n` high). Changes on the request inputs after acceptance do not alter the access in progress.
- R2: A fetch always makes exactly two data phases (`bus_irdy_n` low). Each has `bus_be_n` = 0000 and `bus_ad_oe` low. Every fetch address phase is followed by one turnaround cycle, with `bus_irdy_n` high, before the first data phase.
- R3: In layout 0 the fetch reads offset 00h, then offset 04h. Word A (offset 00h) gives `rsp_md0` = {8'h00, A[23:0]}. Words A and B (offset 04h) give `rsp_md1` = {A[31:24], 8'h00, B[15:0]}. Word B gives `rsp_md2` = B[31:16].
- R4: In layouts 1 and 3 the fetch reads offset 04h into `rsp_md1`, then offset 00h into `rsp_md0`. These are two separate accesses, each with its own address phase.
- R5: In layout 2 the fetch reads offset 04h (MD1), then offset 08h (MD0). With the read-burst flag clear, these are two separate accesses. With it set, there is one address phase at 04h and two consecutive data phases with no cycle between them.
- R6: Both burst flags are ignored in layouts 0, 1 and 3.
- R7: An update with the last flag set makes two data phases: the status word with `bus_be_n` = 0000, then the ownership word. The status offset is 04h in layout 0, 08h in layouts 1 and 3, and 00h in layout 2.
- R8: An update with the last flag clear makes one data phase, which carries the ownership word only.
- R9: The ownership transfer goes to offset 00h in layout 0, with `bus_be_n` = 0111 and data {own[15:8], 24'h0}. In all other layouts it goes to offset 04h, with `bus_be_n` = 0011 and data {own[15:0], 16'h0}.
- R10: Every update data phase, burst or not, is preceded by exactly one cycle inside the access in which `bus_irdy_n` is high.
- R11: In layout 2 with the write-burst flag set, a last-buffer update uses one address phase at 00h, followed by the status data phase and then the ownership data phase.
- R12: `done` is high for exactly one cycle, in the cycle after the final data phase. The `rsp_*` fields are valid in that cycle.
- R13: Separate accesses within one request are separated by GAP_CYCLES cycles with the bus released. Transfer addresses are the base plus the offset, modulo 2^ADDR_W, zero-extended on `bus_ad_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = update descriptor, 0 = fetch |
| req_last | input | 1 | Buffer is single or last in chain |
| req_layout | input | 2 | Descriptor layout code |
| req_rd_burst | input | 1 | Read burst permitted |
| req_wr_burst | input | 1 | Write burst permitted |
| req_base | input | ADDR_W | Descriptor base address |
| req_status | input | 32 | Status word for updates |
| req_own | input | 16 | Ownership word for updates (bit 15 = owner) |
| done | output | 1 | One-cycle completion pulse |
| rsp_md0 | output | 32 | Fetched descriptor word 0 |
| rsp_md1 | output | 32 | Fetched descriptor word 1 |
| rsp_md2 | output | 16 | Fetched word 2 (layout 0 only) |
| bus_frame_n | output | 1 | Low while an access owns the bus |
| bus_cmd_wr | output | 1 | High in a write address phase |
| bus_ad_out | output | 32 | Address or write data |
| bus_ad_oe | output | 1 | Drive enable for `bus_ad_out` |
| bus_ad_in | input | 32 | Read data from target |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_irdy_n | output | 1 | Active-low initiator ready (data phase) |

## Verification
The bench builds the block with ADDR_W = 20 and GAP_CYCLES = 2. The narrow address lets a descriptor based just below the top of the address space wrap its 08h offset around to zero. The two-cycle gap exercises the gap counter past a single step and makes the idle spacing between separate accesses visible in the measured request latency. The bench checks the transfer order, offsets, byte enables, wait-state counts and completion latency for every layout and flag combination.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;

  typedef enum logic [1:0] {
    LAY_16  = 2'd0,
    LAY_32  = 2'd1,
    LAY_32B = 2'd2,
    LAY_RSV = 2'd3
  } layout_e;

  // one data transfer of an access plan
  typedef struct packed {
    logic [3:0] off;
    logic [3:0] be_n;
    logic       own;
  } xfer_t;

  typedef struct packed {
    xfer_t [1:0] x;
    logic        two;
    logic        burst;
  } plan_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_TURN = 3'd2,
    ST_WAIT = 3'd3,
    ST_DATA = 3'd4,
    ST_GAP  = 3'd5
  } st_e;

endpackage

// File: rtl/desc_plan.sv
module desc_plan
  import desc_seq_pkg::*;
(
  input  logic       wr,
  input  logic       last,
  input  logic [1:0] layout,
  input  logic       rd_burst,
  input  logic       wr_burst,
  output plan_t      plan
);

  layout_e    lay;
  logic [3:0] own_off;
  logic [3:0] own_be;
  logic [3:0] sts_off;
  xfer_t      own_x;
  xfer_t      sts_x;

  always_comb begin
    lay = (layout == 2'd3) ? LAY_32 : layout_e'(layout);
  end

  // offsets and lane masks for the update transfers
  always_comb begin
    own_off = (lay == LAY_16) ? 4'h0 : 4'h4;
    own_be  = (lay == LAY_16) ? 4'b0111 : 4'b0011;
    case (lay)
      LAY_16:  sts_off = 4'h4;
      LAY_32B: sts_off = 4'h0;
      default: sts_off = 4'h8;
    endcase
    own_x = '{off: own_off, be_n: own_be, own: 1'b1};
    sts_x = '{off: sts_off, be_n: 4'b0000, own: 1'b0};
  end

  always_comb begin
    plan = '0;
    if (!wr) begin
      plan.two = 1'b1;
      plan.x[0].be_n = 4'b0000;
      plan.x[1].be_n = 4'b0000;
      case (lay)
        LAY_16: begin
          plan.x[0].off = 4'h0;
          plan.x[1].off = 4'h4;
        end
        LAY_32B: begin
          plan.x[0].off = 4'h4;
          plan.x[1].off = 4'h8;
          plan.burst    = rd_burst;
        end
        default: begin
          plan.x[0].off = 4'h4;
          plan.x[1].off = 4'h0;
        end
      endcase
    end else if (last) begin
      plan.two   = 1'b1;
      plan.x[0]  = sts_x;
      plan.x[1]  = own_x;
      plan.burst = (lay == LAY_32B) && wr_burst;
    end else begin
      plan.two  = 1'b0;
      plan.x[0] = own_x;
      plan.x[1] = own_x;
    end
  end

endmodule

// File: rtl/desc_bus_fsm.sv
module desc_bus_fsm
  import desc_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  wr,
  input  plan_t plan,
  output st_e   st,
  output logic  idx,
  output logic  done
);

  localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES + 1) : 1;
  localparam logic [GW-1:0] GAP_LOAD = GW'(GAP_CYCLES - 1);

  logic [GW-1:0] gcnt;
  logic          final_beat;

  always_comb final_beat = !plan.two || idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      idx  <= 1'b0;
      done <= 1'b0;
      gcnt <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_ADDR;
          idx <= 1'b0;
        end
        ST_ADDR: st <= wr ? ST_WAIT : ST_TURN;
        ST_TURN: st <= ST_DATA;
        ST_WAIT: st <= ST_DATA;
        ST_DATA: begin
          if (final_beat) begin
            st   <= ST_IDLE;
            idx  <= 1'b0;
            done <= 1'b1;
          end else begin
            idx <= 1'b1;
            if (plan.burst) begin
              st <= wr ? ST_WAIT : ST_DATA;
            end else begin
              st   <= ST_GAP;
              gcnt <= GAP_LOAD;
            end
          end
        end
        ST_GAP: begin
          if (gcnt == '0) st <= ST_ADDR;
          else            gcnt <= gcnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/desc_rd_assemble.sv
module desc_rd_assemble
  import desc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cap_en,
  input  logic        cap_idx,
  input  logic [31:0] ad_in,
  input  logic [1:0]  layout,
  output logic [31:0] md0,
  output logic [31:0] md1,
  output logic [15:0] md2
);

  logic [31:0] word [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word[0] <= '0;
      word[1] <= '0;
    end else if (cap_en) begin
      word[cap_idx] <= ad_in;
    end
  end

  always_comb begin
    if (layout == LAY_16) begin
      md0 = {8'h00, word[0][23:0]};
      md1 = {word[0][31:24], 8'h00, word[1][15:0]};
      md2 = word[1][31:16];
    end else begin
      md1 = word[0];
      md0 = word[1];
      md2 = '0;
    end
  end

endmodule

// File: rtl/desc_bus_seq.sv
module desc_bus_seq
  import desc_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int GAP_CYCLES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_last,
  input  logic [1:0]        req_layout,
  input  logic              req_rd_burst,
  input  logic              req_wr_burst,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [31:0]       req_status,
  input  logic [15:0]       req_own,
  output logic              done,
  output logic [31:0]       rsp_md0,
  output logic [31:0]       rsp_md1,
  output logic [15:0]       rsp_md2,
  output logic              bus_frame_n,
  output logic              bus_cmd_wr,
  output logic [31:0]       bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [31:0]       bus_ad_in,
  output logic [3:0]        bus_be_n,
  output logic              bus_irdy_n
);

  // captured request
  logic              c_wr, c_last, c_rdb, c_wrb;
  logic [1:0]        c_lay;
  logic [ADDR_W-1:0] c_base;
  logic [31:0]       c_status;
  logic [15:0]       c_own;

  plan_t       plan;
  st_e         st;
  logic        idx;
  logic        start;
  xfer_t       cur;
  logic [ADDR_W-1:0] xaddr;
  logic [31:0] own_word;
  logic [31:0] wdata;
  logic        in_addr, in_beat, wr_beat;

  always_comb begin
    req_ready = (st == ST_IDLE);
    start     = req_valid && req_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_wr     <= 1'b0;
      c_last   <= 1'b0;
      c_rdb    <= 1'b0;
      c_wrb    <= 1'b0;
      c_lay    <= '0;
      c_base   <= '0;
      c_status <= '0;
      c_own    <= '0;
    end else if (start) begin
      c_wr     <= req_write;
      c_last   <= req_last;
      c_rdb    <= req_rd_burst;
      c_wrb    <= req_wr_burst;
      c_lay    <= req_layout;
      c_base   <= req_base;
      c_status <= req_status;
      c_own    <= req_own;
    end
  end

  desc_plan u_plan (
    .wr       (c_wr),
    .last     (c_last),
    .layout   (c_lay),
    .rd_burst (c_rdb),
    .wr_burst (c_wrb),
    .plan     (plan)
  );

  desc_bus_fsm #(.GAP_CYCLES(GAP_CYCLES)) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .wr    (c_wr),
    .plan  (plan),
    .st    (st),
    .idx   (idx),
    .done  (done)
  );

  desc_rd_assemble u_asm (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en  ((st == ST_DATA) && !c_wr),
    .cap_idx (idx),
    .ad_in   (bus_ad_in),
    .layout  (c_lay),
    .md0     (rsp_md0),
    .md1     (rsp_md1),
    .md2     (rsp_md2)
  );

  // bus datapath
  always_comb begin
    cur      = plan.x[idx];
    xaddr    = c_base + ADDR_W'(cur.off);
    own_word = (c_lay == LAY_16) ? {c_own[15:8], 24'h0} : {c_own, 16'h0};
    wdata    = cur.own ? own_word : c_status;
    in_addr  = (st == ST_ADDR);
    in_beat  = (st == ST_TURN) || (st == ST_WAIT) || (st == ST_DATA);
    wr_beat  = c_wr && ((st == ST_WAIT) || (st == ST_DATA));

    bus_frame_n = !(in_addr || in_beat);
    bus_cmd_wr  = in_addr && c_wr;
    bus_ad_oe   = in_addr || wr_beat;
    bus_ad_out  = in_addr ? 32'(xaddr) : (wr_beat ? wdata : 32'h0);
    bus_be_n    = in_beat ? cur.be_n : 4'hF;
    bus_irdy_n  = (st != ST_DATA);
  end

endmodule

// File: rtl/desc_bus_seq_chk.sv
module desc_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       done,
  input logic       bus_frame_n,
  input logic       bus_cmd_wr,
  input logic       bus_ad_oe,
  input logic [3:0] bus_be_n,
  input logic       bus_irdy_n
);

  logic prev_frame_n;
  logic acc_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_frame_n <= 1'b1;
      acc_wr       <= 1'b0;
    end else begin
      prev_frame_n <= bus_frame_n;
      if (!bus_frame_n && prev_frame_n) acc_wr <= bus_cmd_wr;
    end
  end

  AST_READY_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_frame_n); // R1

  AST_IRDY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_irdy_n |-> !bus_frame_n); // R2

  AST_READ_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_irdy_n && !acc_wr) |-> (bus_be_n == 4'b0000 && !bus_ad_oe)); // R2

  AST_WRITE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_irdy_n && acc_wr) |-> bus_ad_oe); // R7

  AST_WRITE_WAIT_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_irdy_n && acc_wr) |-> ($past(bus_irdy_n) && !$past(bus_frame_n))); // R10

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12

  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(bus_irdy_n)); // R12

endmodule

bind desc_bus_seq desc_bus_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .done        (done),
  .bus_frame_n (bus_frame_n),
  .bus_cmd_wr  (bus_cmd_wr),
  .bus_ad_oe   (bus_ad_oe),
  .bus_be_n    (bus_be_n),
  .bus_irdy_n  (bus_irdy_n)
);

// File: tb/sim_desc_bus_seq.sv
`timescale 1ns/1ps
module sim_desc_bus_seq;

  localparam int AW  = 20;
  localparam int GAP = 2;
  localparam logic [31:0] AMASK = (32'h1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic          req_last = 1'b0;
  logic [1:0]    req_layout = '0;
  logic          req_rd_burst = 1'b0;
  logic          req_wr_burst = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [31:0]   req_status = '0;
  logic [15:0]   req_own = '0;
  logic          done;
  logic [31:0]   rsp_md0, rsp_md1;
  logic [15:0]   rsp_md2;
  logic          bus_frame_n, bus_cmd_wr, bus_ad_oe, bus_irdy_n;
  logic [31:0]   bus_ad_out;
  logic [31:0]   bus_ad_in = '0;
  logic [3:0]    bus_be_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  desc_bus_seq #(.ADDR_W(AW), .GAP_CYCLES(GAP)) u0 (.*);

  // transfer log filled by the target model
  logic [31:0] t_addr [0:7];
  logic [31:0] t_data [0:7];
  logic [3:0]  t_be   [0:7];
  logic        t_wr   [0:7];
  int          t_pre  [0:7];
  int          n_t, n_acc, lat;
  logic [31:0] cur_a;
  logic        cur_w, prev_fn = 1'b1;
  int          beat, pre;
  logic [31:0] g_md0, g_md1;
  logic [15:0] g_md2;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1234_5678;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_frame_n && prev_fn) begin
        cur_a = bus_ad_out;
        cur_w = bus_cmd_wr;
        beat  = 0;
        pre   = 0;
        n_acc++;
      end else if (!bus_frame_n) begin
        bus_ad_in = pat((cur_a + 32'(beat * 4)) & AMASK);
        if (bus_irdy_n) pre++;
        else begin
          if (n_t < 8) begin
            t_addr[n_t] = (cur_a + 32'(beat * 4)) & AMASK;
            t_data[n_t] = cur_w ? bus_ad_out : bus_ad_in;
            t_be[n_t]   = bus_be_n;
            t_wr[n_t]   = cur_w;
            t_pre[n_t]  = pre;
          end
          n_t++;
          beat++;
          pre = 0;
        end
      end
      prev_fn = bus_frame_n;
    end
  end

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // issue one request and wait for completion; scramble alters inputs after acceptance
  task automatic run(input logic wr, input logic last, input logic [1:0] lay,
                     input logic rb, input logic wb, input logic [AW-1:0] base,
                     input logic [31:0] sts, input logic [15:0] own, input logic scramble);
    @(negedge clk);
    n_t = 0; n_acc = 0;
    req_write = wr; req_last = last; req_layout = lay;
    req_rd_burst = rb; req_wr_burst = wb; req_base = base;
    req_status = sts; req_own = own; req_valid = 1'b1;
    check("R1", "ready when idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    if (scramble) begin
      check("R1", "ready while busy", 32'(req_ready), 32'd0);
      req_layout = 2'd0; req_rd_burst = ~rb; req_wr_burst = ~wb;
      req_base = ~base; req_write = ~wr; req_last = ~last;
      req_status = ~sts; req_own = ~own;
    end
    while (!done && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    g_md0 = rsp_md0; g_md1 = rsp_md1; g_md2 = rsp_md2;
    @(negedge clk);
    check("R12", "done width", 32'(done), 32'd0);
  endtask

  task automatic chk_x(input string rq, input int i, input logic [31:0] a,
                       input logic [3:0] be, input logic [31:0] d,
                       input logic w, input int p);
    check(rq, $sformatf("xfer%0d addr", i), t_addr[i], a & AMASK);
    check(rq, $sformatf("xfer%0d be_n", i), 32'(t_be[i]), 32'(be));
    check(rq, $sformatf("xfer%0d data", i), t_data[i], d);
    check(rq, $sformatf("xfer%0d dir", i), 32'(t_wr[i]), 32'(w));
    check(rq, $sformatf("xfer%0d pre-wait", i), 32'(t_pre[i]), 32'(p));
  endtask

  task automatic t_reset;
    check("R1", "reset ready", 32'(req_ready), 32'd1);
    check("R1", "reset frame_n", 32'(bus_frame_n), 32'd1);
    check("R2", "reset irdy_n", 32'(bus_irdy_n), 32'd1);
    check("R12", "reset done", 32'(done), 32'd0);
    check("R2", "reset be_n", 32'(bus_be_n), 32'hF);
  endtask

  task automatic t_read16;
    logic [31:0] b = 32'h01230, a, c;
    run(1'b0, 1'b0, 2'd0, 1'b1, 1'b1, b[AW-1:0], 32'h0, 16'h0, 1'b0);
    a = pat(b); c = pat(b + 4);
    check("R2", "transfer count", 32'(n_t), 32'd2);
    check("R6", "access count (burst flag ignored)", 32'(n_acc), 32'd2);
    chk_x("R3", 0, b, 4'h0, a, 1'b0, 1);
    chk_x("R3", 1, b + 4, 4'h0, c, 1'b0, 1);
    check("R3", "md0", g_md0, {8'h00, a[23:0]});
    check("R3", "md1", g_md1, {a[31:24], 8'h00, c[15:0]});
    check("R3", "md2", 32'(g_md2), 32'(c[31:16]));
    check("R13", "latency two accesses", 32'(lat), 32'(7 + GAP));
  endtask

  task automatic t_read32(input logic [1:0] lay);
    logic [31:0] b = 32'h04440;
    run(1'b0, 1'b0, lay, 1'b1, 1'b0, b[AW-1:0], 32'h0, 16'h0, 1'b0);
    check("R6", "access count (burst flag ignored)", 32'(n_acc), 32'd2);
    chk_x("R4", 0, b + 4, 4'h0, pat(b + 4), 1'b0, 1);
    chk_x("R4", 1, b, 4'h0, pat(b), 1'b0, 1);
    check("R4", "md1", g_md1, pat(b + 4));
    check("R4", "md0", g_md0, pat(b));
  endtask

  task automatic t_read32b_single;
    logic [31:0] b = 32'hFFFF8;
    run(1'b0, 1'b0, 2'd2, 1'b0, 1'b1, b[AW-1:0], 32'h0, 16'h0, 1'b0);
    check("R5", "access count no burst", 32'(n_acc), 32'd2);
    chk_x("R5", 0, b + 4, 4'h0, pat(32'hFFFFC), 1'b0, 1);
    chk_x("R13", 1, 32'h0, 4'h0, pat(32'h0), 1'b0, 1);
    check("R5", "md1", g_md1, pat(32'hFFFFC));
    check("R5", "md0", g_md0, pat(32'h0));
  endtask

  task automatic t_read32b_burst;
    logic [31:0] b = 32'h08800;
    run(1'b0, 1'b0, 2'd2, 1'b1, 1'b0, b[AW-1:0], 32'h0, 16'h0, 1'b1);
    check("R5", "access count burst", 32'(n_acc), 32'd1);
    chk_x("R5", 0, b + 4, 4'h0, pat(b + 4), 1'b0, 1);
    chk_x("R5", 1, b + 8, 4'h0, pat(b + 8), 1'b0, 0);
    check("R1", "md1 after scrambled inputs", g_md1, pat(b + 4));
    check("R5", "md0", g_md0, pat(b + 8));
    check("R5", "latency burst read", 32'(lat), 32'd5);
  endtask

  task automatic t_write_last(input logic [1:0] lay, input logic wb,
                              input logic [31:0] soff, input logic [31:0] ooff,
                              input logic [3:0] obe, input int accs);
    logic [31:0] b = 32'h02200, sts = 32'hA5C3_0F1E;
    logic [15:0] own = 16'h8ABC;
    logic [31:0] od;
    od = (lay == 2'd0) ? {own[15:8], 24'h0} : {own, 16'h0};
    run(1'b1, 1'b1, lay, 1'b1, wb, b[AW-1:0], sts, own, 1'b0);
    check("R7", "transfer count", 32'(n_t), 32'd2);
    check(accs == 1 ? "R11" : "R6", "access count", 32'(n_acc), 32'(accs));
    chk_x("R7", 0, b + soff, 4'h0, sts, 1'b1, 1);
    chk_x("R9", 1, b + ooff, obe, od, 1'b1, 1);
    check("R10", "latency", 32'(lat), accs == 1 ? 32'd6 : 32'(7 + GAP));
  endtask

  task automatic t_write_mid(input logic [1:0] lay, input logic [31:0] ooff,
                             input logic [3:0] obe);
    logic [31:0] b = 32'h03300;
    logic [15:0] own = 16'h8001;
    run(1'b1, 1'b0, lay, 1'b1, 1'b1, b[AW-1:0], 32'hDEAD_BEEF, own, 1'b0);
    check("R8", "transfer count", 32'(n_t), 32'd1);
    check("R8", "access count", 32'(n_acc), 32'd1);
    chk_x("R9", 0, b + ooff, obe,
          (lay == 2'd0) ? {own[15:8], 24'h0} : {own, 16'h0}, 1'b1, 1);
    check("R8", "latency", 32'(lat), 32'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_read16();
    t_read32(2'd1);
    t_read32(2'd3);
    t_read32b_single();
    t_read32b_burst();
    t_write_last(2'd0, 1'b1, 32'h4, 32'h0, 4'b0111, 2);
    t_write_last(2'd1, 1'b1, 32'h8, 32'h4, 4'b0011, 2);
    t_write_last(2'd2, 1'b0, 32'h0, 32'h4, 4'b0011, 2);
    t_write_last(2'd2, 1'b1, 32'h0, 32'h4, 4'b0011, 1);
    t_write_mid(2'd0, 32'h0, 4'b0111);
    t_write_mid(2'd1, 32'h4, 4'b0011);
    t_write_mid(2'd2, 32'h4, 4'b0011);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule